// File: doc/BRIEF.md
# Counted I2C Receive Burst Engine

This block gathers a counted run of bytes from an I2C bus engine into a receive FIFO. Software starts a burst with one write to the control register. That write carries the number of bytes to collect and a flag that says whether the final byte gets a NAK. The engine then asks the bus engine for bytes one at a time. Every byte is answered with ACK, except that the final byte is answered with NAK when the flag is set. Once the counted bytes have all arrived, a read-complete status flag is raised.

Software drains the bytes in arrival order through a read-out register. One burst holds at most `DEPTH` bytes, so a long read is split into several bursts. Only the last of those bursts sets the NAK flag, which ends the read on the bus with a NAK on its very last byte. Address phases, start and stop conditions and bus timing all belong to the bus engine. The bus engine delivers each byte with a one-cycle strobe, and only while this block is requesting bytes.

Register map. Each register is 8 bits wide and is selected by a 2-bit address:
- 0: control. Bits [6:0] hold the byte count and bit 7 is the NAK-last flag.
- 1: status. Bit 4 is read complete; writing a 1 to bit 4 clears it.
- 2: FIFO status. Bit 2 is receive-FIFO-empty.
- 3: read-out. Each read pops the next byte.

All other bits read as zero. A read returns its data in the cycle after the read strobe.

Top module: `i2c_rx_burst`

## Requirements
- R1: A control write (address 0) while idle takes the byte count from bits [6:0] and the NAK-last flag from bit 7, and starts the burst. When the count is non-zero, `rx_req` is high in the next cycle.
- R2: Each byte accepted on `rx_data` is stored. Reads of address 3 return the stored bytes in arrival order, one byte per read, in the cycle after the read strobe.
- R3: `rx_nak` is high only while the final byte of a burst is being requested and the NAK-last flag of that burst is set. Every other requested byte has `rx_nak` low (ACK).
- R4: In the cycle after the final counted byte is accepted, `rx_req` is low and status bit 4 (read complete) is set.
- R5: A count of zero sets status bit 4 in the next cycle and never raises `rx_req`.
- R6: A count larger than `DEPTH` is treated as `DEPTH`.
- R7: A control write while a burst is running has no effect on the burst's length or on its NAK-last flag.
- R8: Status bit 4 stays set until a status write (address 1) with bit 4 set clears it. Starting a non-zero burst also clears it.
- R9: FIFO status bit 2 is 1 exactly when the receive FIFO holds no bytes.
- R10: A read of address 3 while the FIFO is empty returns 0 and removes nothing, so the next byte stored is the next byte returned.
- R11: `rx_req` is low while the FIFO is full. A strobe on `rx_valid` while `rx_req` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 2 | Register write address |
| reg_wr_data | input | 8 | Register write data |
| reg_rd_en | input | 1 | Register read strobe |
| reg_rd_addr | input | 2 | Register read address |
| reg_rd_data | output | 8 | Read data, valid the cycle after the strobe |
| rx_req | output | 1 | Engine wants the next byte from the bus |
| rx_nak | output | 1 | Answer the requested byte with NAK (1) or ACK (0) |
| rx_valid | input | 1 | Bus engine delivers a byte this cycle |
| rx_data | input | 8 | Received byte |

## Verification
The bench builds the block with `DEPTH` set to 8. This makes every count from 9 to 127 a clamping case, so the R6 limit can be reached with only a few random draws. With this depth the FIFO fills within one burst, which brings the full-FIFO stall, the ignored strobe and the resume after a pop into range. The read and write pointers also wrap many times during the random bursts, which tests arrival order across the wrap point.

// File: rtl/i2crx_pkg.sv
package i2crx_pkg;
    localparam int REG_W     = 8;
    localparam int BYTE_W    = 8;
    localparam int NAK_BIT   = 7;
    localparam int DONE_BIT  = 4;
    localparam int EMPTY_BIT = 2;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_STAT  = 2'd1,
        SEL_FSTAT = 2'd2,
        SEL_DOUT  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/i2crx_fifo.sv
module i2crx_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t q, d;
    logic [W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign empty = (q.cnt == '0);
    assign full  = (q.cnt == CW'(DEPTH));
    assign dout  = mem_q[q.rp];

    always_comb begin
        d       = q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (do_push) d.wp = bump(q.wp);
        if (do_pop)  d.rp = bump(q.rp);
        if (do_push && !do_pop)      d.cnt = q.cnt + CW'(1);
        else if (do_pop && !do_push) d.cnt = q.cnt - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[q.wp] <= din;
    end
endmodule

// File: rtl/i2crx_burst_ctrl.sv
module i2crx_burst_ctrl #(
    parameter int DEPTH = 64,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] start_cnt,
    input  logic             start_nak,
    input  logic             clr_done,
    input  logic             rx_valid,
    input  logic             fifo_full,
    output logic             rx_req,
    output logic             rx_nak,
    output logic             push,
    output logic             done
);
    typedef struct packed {
        logic             busy;
        logic             nak_last;
        logic [CNT_W-1:0] remain;
        logic             done;
    } ctrl_st_t;

    ctrl_st_t q, d;
    logic accept;

    assign rx_req = q.busy && !fifo_full;
    assign rx_nak = rx_req && q.nak_last && (q.remain == CNT_W'(1));
    assign push   = accept;
    assign done   = q.done;

    always_comb begin
        d      = q;
        accept = rx_req && rx_valid;
        if (clr_done) d.done = 1'b0;
        if (start && !q.busy) begin
            if (start_cnt == '0) begin
                d.done = 1'b1;
            end else begin
                d.busy     = 1'b1;
                d.remain   = start_cnt;
                d.nak_last = start_nak;
                d.done     = 1'b0;
            end
        end
        if (accept) begin
            d.remain = q.remain - CNT_W'(1);
            if (q.remain == CNT_W'(1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/i2c_rx_burst.sv
module i2c_rx_burst #(
    parameter int DEPTH = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr_en,
    input  logic [1:0] reg_wr_addr,
    input  logic [7:0] reg_wr_data,
    input  logic       reg_rd_en,
    input  logic [1:0] reg_rd_addr,
    output logic [7:0] reg_rd_data,
    output logic       rx_req,
    output logic       rx_nak,
    input  logic       rx_valid,
    input  logic [7:0] rx_data
);
    import i2crx_pkg::*;

    localparam int CNT_W   = $clog2(DEPTH + 1);
    localparam int FIELD_W = NAK_BIT;

    typedef struct packed {
        logic [REG_W-1:0] rd_data;
    } top_st_t;

    top_st_t q, d;

    logic               wr_ctrl, clr_done, rd_pop;
    logic [FIELD_W-1:0] cnt_field;
    logic [CNT_W-1:0]   cnt_eff;
    logic               push, done;
    logic               fifo_empty, fifo_full;
    logic [BYTE_W-1:0]  fifo_dout;

    assign wr_ctrl   = reg_wr_en && (reg_wr_addr == SEL_CTRL);
    assign clr_done  = reg_wr_en && (reg_wr_addr == SEL_STAT) && reg_wr_data[DONE_BIT];
    assign cnt_field = reg_wr_data[FIELD_W-1:0];
    assign cnt_eff   = (cnt_field > FIELD_W'(DEPTH)) ? CNT_W'(DEPTH) : CNT_W'(cnt_field);
    assign rd_pop    = reg_rd_en && (reg_rd_addr == SEL_DOUT) && !fifo_empty;

    i2crx_burst_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (wr_ctrl),
        .start_cnt (cnt_eff),
        .start_nak (reg_wr_data[NAK_BIT]),
        .clr_done  (clr_done),
        .rx_valid  (rx_valid),
        .fifo_full (fifo_full),
        .rx_req    (rx_req),
        .rx_nak    (rx_nak),
        .push      (push),
        .done      (done)
    );

    i2crx_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   (rx_data),
        .pop   (rd_pop),
        .dout  (fifo_dout),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    always_comb begin
        d = q;
        if (reg_rd_en) begin
            d.rd_data = '0;
            case (reg_rd_addr)
                SEL_STAT:  d.rd_data[DONE_BIT]  = done;
                SEL_FSTAT: d.rd_data[EMPTY_BIT] = fifo_empty;
                SEL_DOUT:  d.rd_data = fifo_empty ? '0 : fifo_dout;
                default:   d.rd_data = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign reg_rd_data = q.rd_data;
endmodule

// File: rtl/i2crx_checker.sv
module i2crx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_req,
    input logic       rx_nak,
    input logic       rx_valid,
    input logic       fifo_full,
    input logic       fifo_empty,
    input logic       push,
    input logic       wr_ctrl,
    input logic       done,
    input logic       reg_rd_en,
    input logic [1:0] reg_rd_addr,
    input logic [7:0] reg_rd_data
);
    // R11: no byte is requested while the FIFO is full
    a_r11_no_req_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !rx_req);

    // R3: a NAK answer is only given for a byte that is being requested
    a_r3_nak_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        rx_nak |-> rx_req);

    // R4: a byte taken with NAK closes the burst
    a_r4_req_drops_after_nak: assert property (@(posedge clk) disable iff (!rst_n)
        (push && rx_nak) |=> !rx_req);

    // R5: read complete only rises after a start or an accepted byte
    a_r5_done_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(push || wr_ctrl));

    // R10: an empty read-out returns zero
    a_r10_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && reg_rd_addr == 2'd3 && fifo_empty) |=> (reg_rd_data == 8'h00));

    // R9: an accepted byte makes the FIFO non-empty
    a_r9_push_fills: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !fifo_empty);

    // R11: a strobe is only taken while requesting
    a_r11_push_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (rx_req && rx_valid));
endmodule

bind i2c_rx_burst i2crx_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_req      (rx_req),
    .rx_nak      (rx_nak),
    .rx_valid    (rx_valid),
    .fifo_full   (fifo_full),
    .fifo_empty  (fifo_empty),
    .push        (push),
    .wr_ctrl     (wr_ctrl),
    .done        (done),
    .reg_rd_en   (reg_rd_en),
    .reg_rd_addr (reg_rd_addr),
    .reg_rd_data (reg_rd_data)
);

// File: tb/test_i2c_rx_burst.sv
module test_i2c_rx_burst;
    localparam int DEPTH = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [1:0] reg_wr_addr = '0;
    logic [7:0] reg_wr_data = '0;
    logic       reg_rd_en = 1'b0;
    logic [1:0] reg_rd_addr = '0;
    logic [7:0] reg_rd_data;
    logic       rx_req, rx_nak;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;

    int checks = 0;
    int errors = 0;
    logic [7:0] model_q[$];

    always #10 clk = ~clk;

    i2c_rx_burst #(.DEPTH(DEPTH)) i_i2c_rx_burst (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .reg_rd_en(reg_rd_en), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .rx_req(rx_req), .rx_nak(rx_nak), .rx_valid(rx_valid), .rx_data(rx_data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int eff_count(input int field);
        return (field > DEPTH) ? DEPTH : field;
    endfunction

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = v;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_rd_en = 1'b1; reg_rd_addr = a;
        @(negedge clk);
        reg_rd_en = 1'b0;
        v = reg_rd_data;
    endtask

    // Called at a negedge; delivers one byte once requested
    task automatic feed(input logic [7:0] b, input bit exp_nak, input string tag);
        int wait_n = 0;
        while (!rx_req && wait_n < 1000) begin
            @(negedge clk);
            wait_n++;
        end
        chk(rx_nak == exp_nak, tag, rx_nak, exp_nak);
        rx_valid = 1'b1; rx_data = b;
        @(negedge clk);
        rx_valid = 1'b0;
        model_q.push_back(b);
    endtask

    task automatic pop_check(input string tag);
        logic [7:0] v;
        logic [7:0] e;
        rd(2'd3, v);
        e = (model_q.size() > 0) ? model_q.pop_front() : 8'h00;
        chk(v == e, tag, v, e);
    endtask

    task automatic drain(input string tag);
        logic [7:0] v;
        while (model_q.size() > 0) pop_check(tag);
        rd(2'd2, v);
        chk(v == 8'h04, "R9 empty flag after drain", v, 8'h04);
    endtask

    task automatic run_burst(input int field, input bit nak, input string tag);
        logic [7:0] v;
        int n = eff_count(field);
        wr(2'd0, {nak, 7'(field)});
        if (n == 0) begin
            chk(rx_req == 1'b0, "R5 no request for zero count", rx_req, 0);
            rd(2'd1, v);
            chk(v == 8'h10, "R5 zero count completes", v, 8'h10);
        end else begin
            chk(rx_req == 1'b1, "R1 request after start", rx_req, 1);
            for (int i = 0; i < n; i++)
                feed(8'($urandom_range(0, 255)), (i == n - 1) && nak, tag);
            chk(rx_req == 1'b0, "R4 request drops after last", rx_req, 0);
            rd(2'd1, v);
            chk(v == 8'h10, "R4 read complete set", v, 8'h10);
        end
        wr(2'd1, 8'h10);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog run hung actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        chk(rx_req == 1'b0, "R1 reset no request", rx_req, 0);
        rd(2'd1, v); chk(v == 8'h00, "R8 reset status clear", v, 0);
        rd(2'd2, v); chk(v == 8'h04, "R9 reset fifo empty", v, 8'h04);
        rd(2'd3, v); chk(v == 8'h00, "R10 empty read zero", v, 0);

        // Basic burst with NAK last, and one with ACK last
        run_burst(3, 1'b1, "R3 nak pattern nak-last");
        rd(2'd2, v); chk(v == 8'h00, "R9 not empty with data", v, 0);
        drain("R2 arrival order");
        run_burst(4, 1'b0, "R3 ack on every byte");
        drain("R2 arrival order");

        // Zero count
        run_burst(0, 1'b1, "R5 zero");

        // Clamp
        run_burst(100, 1'b1, "R6 clamped burst nak on byte DEPTH");
        drain("R6 clamped data");

        // R8: done stays until cleared; start clears it
        wr(2'd0, 8'h00);
        rd(2'd1, v); chk(v == 8'h10, "R8 done set", v, 8'h10);
        rd(2'd1, v); chk(v == 8'h10, "R8 done sticky", v, 8'h10);
        wr(2'd1, 8'h00);
        rd(2'd1, v); chk(v == 8'h10, "R8 write without bit4 keeps done", v, 8'h10);
        wr(2'd0, 8'h02);
        rd(2'd1, v); chk(v == 8'h00, "R8 start clears done", v, 0);
        feed(8'h11, 1'b0, "R8 burst byte");
        feed(8'h22, 1'b0, "R8 burst byte");
        wr(2'd1, 8'h10);
        rd(2'd1, v); chk(v == 8'h00, "R8 cleared by write", v, 0);
        drain("R2 order");

        // R7: control write while busy ignored
        wr(2'd0, 8'h04);
        feed(8'h31, 1'b0, "R7 byte");
        feed(8'h32, 1'b0, "R7 byte");
        wr(2'd0, 8'h85);
        feed(8'h33, 1'b0, "R7 byte");
        feed(8'h34, 1'b0, "R7 last byte keeps ACK");
        chk(rx_req == 1'b0, "R7 burst length unchanged", rx_req, 0);
        wr(2'd1, 8'h10);
        drain("R7 data order");

        // R10: empty read does not move pointer
        rd(2'd3, v); chk(v == 8'h00, "R10 empty read zero", v, 0);
        wr(2'd0, 8'h81);
        feed(8'h5A, 1'b1, "R10 single byte nak");
        pop_check("R10 next byte after empty read");
        wr(2'd1, 8'h10);

        // R11: full stall
        run_burst(DEPTH, 1'b0, "R11 fill");
        wr(2'd0, 8'h83);
        chk(rx_req == 1'b0, "R11 no request when full", rx_req, 1'b0);
        rx_valid = 1'b1; rx_data = 8'hEE;
        @(negedge clk);
        rx_valid = 1'b0;
        chk(rx_req == 1'b0, "R11 still stalled", rx_req, 0);
        pop_check("R11 pop while stalled");
        chk(rx_req == 1'b1, "R11 resume after pop", rx_req, 1);
        feed(8'hA1, 1'b0, "R11 resumed byte");
        chk(rx_req == 1'b0, "R11 full again", rx_req, 0);
        pop_check("R11 pop");
        pop_check("R11 pop");
        feed(8'hA2, 1'b0, "R11 byte");
        feed(8'hA3, 1'b1, "R11 last byte nak");
        rd(2'd1, v); chk(v == 8'h10, "R4 stalled burst completes", v, 8'h10);
        wr(2'd1, 8'h10);
        drain("R11 strobe ignored, order kept");

        // Random bursts
        for (int k = 0; k < 25; k++) begin
            int f = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 127) : $urandom_range(0, DEPTH);
            run_burst(f, 1'($urandom_range(0, 1)), "R3 random burst answer");
            drain("R2 random order");
            if ($urandom_range(0, 1) == 1) begin
                rd(2'd3, v); chk(v == 8'h00, "R10 random empty read", v, 0);
            end
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule